// File: doc/BRIEF.md
# Bypassed Register Rename Table

This block holds the mapping from architectural register numbers to physical register numbers for a renaming front end. Several read ports and several write ports share one table. Each read address is expected to come straight from the instruction buffer. The table lookup therefore starts in the decode cycle, and the physical index comes out of a register one cycle later.

Write requests are not put into the table at once. They are captured in a latch stage, and the latched requests update the table on the following clock edge. Two bypass points hide this split from readers:

- The early lookup uses the latched requests that are still on their way into the table.
- The late output uses the requests latched in the same cycle the read address was presented.

As a result, every read returns the mapping as it stands after all writes of its own cycle. A full-table restore input replaces the whole mapping in one step. It is used after a pipeline recovery.

Top module: `rename_table_bypass`

## Requirements
- R1: After synchronous active-low reset, architectural register i maps to physical register i for every i.
- R2: A read address presented in cycle t produces its physical index on the matching read data port in cycle t+1. That output depends only on state captured at the clock edge.
- R3: A write presented in the same cycle as a read of the same architectural register is visible in that read's data one cycle later.
- R4: A write is held in a latch for one cycle and then committed to the table. A read presented while the write is only latched still returns the new value, and later reads keep returning it.
- R5: When several write ports target the same architectural register in one cycle, the highest-numbered write port wins. This applies both to the table contents and to the bypassed read data.
- R6: Architectural register 0 always reads as physical register 0. Writes addressed to it have no effect, in the same cycle and afterwards.
- R7: When restore is high in cycle t, the following take effect:
  - The table is replaced by the restore vector, where entry i sits at bits [i*PHYS_W +: PHYS_W] and entry 0 is forced to 0.
  - Reads presented in cycle t already return the restored values.
  - Writes presented in cycle t, and writes latched from cycle t-1, are discarded.
- R8: The read ports are independent. Port p takes its address from bits [p*ARCH_W +: ARCH_W] of the read address bus and returns its index on bits [p*PHYS_W +: PHYS_W] of the read data bus. Write ports use the same field layout.
- R9: While reset is held, after at least one clock edge, every read data port outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_arch_i | input | NUM_RD*ARCH_W | Architectural index for each read port, presented in the decode cycle |
| rd_phys_o | output | NUM_RD*PHYS_W | Physical index for each read port, valid one cycle after its address |
| wr_valid_i | input | NUM_WR | Write request valid, one bit per write port |
| wr_arch_i | input | NUM_WR*ARCH_W | Architectural index for each write port |
| wr_phys_i | input | NUM_WR*PHYS_W | New physical index for each write port |
| restore_i | input | 1 | Replace the whole table with restore_map_i |
| restore_map_i | input | ARCH_REGS*PHYS_W | Full mapping to load on restore |

## Verification
The hardest case to reach is a read whose correct answer exists only in the write latch, or only on the write ports of the same cycle. It becomes harder when several write ports hit that register at once, or when a restore arrives in the same cycle. Directed sequences set up these cases deliberately:

- a write followed immediately by reads in the next cycles;
- four-port writes to a single register;
- a restore that races a pending write.

A long random phase then confines addresses to a handful of registers, so latch hits, same-cycle hits and port collisions happen many times under varied ordering. Every result is compared against a plain reference map kept by the scoreboard.

// File: rtl/rt_pkg.sv
// Shared configuration and types for the rename table.
// Assumes PHYS_REGS >= ARCH_REGS so that the reset identity map fits.
package rt_pkg;
    localparam int unsigned ARCH_REGS = 32;
    localparam int unsigned PHYS_REGS = 64;
    localparam int unsigned ARCH_W    = $clog2(ARCH_REGS);
    localparam int unsigned PHYS_W    = $clog2(PHYS_REGS);

    typedef logic [ARCH_W-1:0] arch_idx_t;
    typedef logic [PHYS_W-1:0] phys_idx_t;

    // One write request: valid, target architectural register, new physical register.
    typedef struct packed {
        logic      vld;
        arch_idx_t arch;
        phys_idx_t phys;
    } wr_req_t;
endpackage

// File: rtl/rt_wr_latch.sv
// Write latch stage: captures this cycle's write requests. The captured
// requests drive the table update and the bypass paths in the next cycle.
// Requests to architectural register 0 are dropped here.
// A restore flushes everything.
// Assumes: synchronous active-low reset.
module rt_wr_latch
    import rt_pkg::*;
#(
    parameter int NUM_WR = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    restore_i,
    input  wr_req_t req_i [NUM_WR],
    output wr_req_t req_q [NUM_WR]
);

    // Capture requests, filtering register 0 and flushing on restore.
    always_ff @(posedge clk) begin
        for (int j = 0; j < NUM_WR; j++) begin
            if (!rst_n || restore_i) begin
                req_q[j] <= '0;
            end else begin
                req_q[j].vld  <= req_i[j].vld && (req_i[j].arch != '0);
                req_q[j].arch <= req_i[j].arch;
                req_q[j].phys <= req_i[j].phys;
            end
        end
    end

    for (genvar j = 0; j < NUM_WR; j++) begin : g_chk
        // R4: an accepted request sits in the latch for exactly the next cycle.
        a_r4_latched: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(req_i[j].vld && !restore_i && req_i[j].arch != '0))
            |-> (req_q[j].vld && req_q[j].phys == $past(req_i[j].phys)))
            else $error("a_r4_latched port %0d", j);
        // R6: a request to register 0 never enters the latch.
        a_r6_no_zero_latch: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(req_i[j].vld && req_i[j].arch == '0))
            |-> !req_q[j].vld)
            else $error("a_r6_no_zero_latch port %0d", j);
    end

    // R7: restore discards whatever was presented alongside it.
    a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restore_i) |-> (req_q[0].vld == 1'b0 && req_q[NUM_WR-1].vld == 1'b0))
        else $error("a_r7_flush");

endmodule

// File: rtl/rt_map_array.sv
// Mapping storage: one physical index per architectural register.
// The latched requests are applied in port order, so the highest port wins.
// A restore takes precedence over the latched requests.
// Assumes: the latch never presents register 0 as valid; synchronous active-low reset.
module rt_map_array
    import rt_pkg::*;
#(
    parameter int NUM_WR = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restore_i,
    input  phys_idx_t restore_map_i [ARCH_REGS],
    input  wr_req_t   apply_i       [NUM_WR],
    output phys_idx_t map_o         [ARCH_REGS]
);

    phys_idx_t map_q [ARCH_REGS];

    // Reset to identity, load on restore, otherwise commit latched writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= phys_idx_t'(i);
        end else if (restore_i) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= (i == 0) ? '0 : restore_map_i[i];
        end else begin
            for (int j = 0; j < NUM_WR; j++) begin
                if (apply_i[j].vld) map_q[apply_i[j].arch] <= apply_i[j].phys;
            end
        end
    end

    assign map_o = map_q;

    // R6: entry 0 stays pinned to physical register 0.
    a_r6_entry0: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> map_q[0] == '0)
        else $error("a_r6_entry0");

    // R1: leaving reset, the top entry holds its own index.
    a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> map_q[ARCH_REGS-1] == phys_idx_t'(ARCH_REGS-1))
        else $error("a_r1_identity");

endmodule

// File: rtl/rt_read_port.sv
// One read port, split over two cycles.
//  - Early stage (decode cycle): looks up the table, lets latched writes that
//    are not yet committed override the lookup, and lets restore override both.
//    The result is registered.
//  - Late stage (next cycle): lets the writes latched at the same edge
//    override the registered result.
// Assumes: latched requests never target register 0.
module rt_read_port
    import rt_pkg::*;
#(
    parameter int NUM_WR = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restore_i,
    input  phys_idx_t restore_map_i [ARCH_REGS],
    input  phys_idx_t map_i         [ARCH_REGS],
    input  wr_req_t   lat_i         [NUM_WR],
    input  arch_idx_t rd_arch_i,
    output phys_idx_t rd_phys_o
);

    phys_idx_t early_phys;
    arch_idx_t arch_q;
    phys_idx_t data_q;

    // Early lookup with pending-write bypass and restore override.
    always_comb begin
        early_phys = map_i[rd_arch_i];
        for (int j = 0; j < NUM_WR; j++) begin
            if (lat_i[j].vld && lat_i[j].arch == rd_arch_i) early_phys = lat_i[j].phys;
        end
        if (restore_i) early_phys = (rd_arch_i == '0) ? '0 : restore_map_i[rd_arch_i];
    end

    // Register the address and the early result across the stage boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_q <= '0;
            data_q <= '0;
        end else begin
            arch_q <= rd_arch_i;
            data_q <= early_phys;
        end
    end

    // Late bypass of writes presented alongside the read address.
    always_comb begin
        rd_phys_o = data_q;
        for (int j = 0; j < NUM_WR; j++) begin
            if (lat_i[j].vld && lat_i[j].arch == arch_q) rd_phys_o = lat_i[j].phys;
        end
    end

    // R7: a read issued with restore returns the restored entry.
    a_r7_restore_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(restore_i))
        |-> rd_phys_o == $past((rd_arch_i == '0) ? '0 : restore_map_i[rd_arch_i]))
        else $error("a_r7_restore_read");

endmodule

// File: rtl/rename_table_bypass.sv
// Top level of the rename table. Unpacks the flat port buses, then connects
// the write latch, the mapping storage and one read port per read lane.
// Assumes: synchronous active-low reset; field p of a flat bus sits at [p*W +: W].
module rename_table_bypass
    import rt_pkg::*;
#(
    parameter int NUM_RD = 4,
    parameter int NUM_WR = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_RD*ARCH_W-1:0]    rd_arch_i,
    output logic [NUM_RD*PHYS_W-1:0]    rd_phys_o,
    input  logic [NUM_WR-1:0]           wr_valid_i,
    input  logic [NUM_WR*ARCH_W-1:0]    wr_arch_i,
    input  logic [NUM_WR*PHYS_W-1:0]    wr_phys_i,
    input  logic                        restore_i,
    input  logic [ARCH_REGS*PHYS_W-1:0] restore_map_i
);

    wr_req_t   wr_req  [NUM_WR];
    wr_req_t   lat_req [NUM_WR];
    phys_idx_t rmap    [ARCH_REGS];
    phys_idx_t map     [ARCH_REGS];

    // Pack each write lane into a request record.
    for (genvar j = 0; j < NUM_WR; j++) begin : g_wr
        assign wr_req[j] = {wr_valid_i[j], wr_arch_i[j*ARCH_W +: ARCH_W], wr_phys_i[j*PHYS_W +: PHYS_W]};
    end

    // Split the restore vector into entries.
    for (genvar i = 0; i < ARCH_REGS; i++) begin : g_rmap
        assign rmap[i] = restore_map_i[i*PHYS_W +: PHYS_W];
    end

    rt_wr_latch #(.NUM_WR(NUM_WR)) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .restore_i (restore_i),
        .req_i     (wr_req),
        .req_q     (lat_req)
    );

    rt_map_array #(.NUM_WR(NUM_WR)) i_array (
        .clk           (clk),
        .rst_n         (rst_n),
        .restore_i     (restore_i),
        .restore_map_i (rmap),
        .apply_i       (lat_req),
        .map_o         (map)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rt_read_port #(.NUM_WR(NUM_WR)) i_port (
            .clk           (clk),
            .rst_n         (rst_n),
            .restore_i     (restore_i),
            .restore_map_i (rmap),
            .map_i         (map),
            .lat_i         (lat_req),
            .rd_arch_i     (rd_arch_i[p*ARCH_W +: ARCH_W]),
            .rd_phys_o     (rd_phys_o[p*PHYS_W +: PHYS_W])
        );
    end

    // R5: the highest write port reaches a same-cycle read of its register.
    a_r5_youngest_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_valid_i[NUM_WR-1] && !restore_i
            && wr_arch_i[NUM_WR*ARCH_W-1 -: ARCH_W] == rd_arch_i[ARCH_W-1:0]
            && wr_arch_i[NUM_WR*ARCH_W-1 -: ARCH_W] != '0))
        |-> rd_phys_o[PHYS_W-1:0] == $past(wr_phys_i[NUM_WR*PHYS_W-1 -: PHYS_W]))
        else $error("a_r5_youngest_bypass");

    // R6: a read of register 0 returns physical register 0.
    a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_arch_i[ARCH_W-1:0] == '0))
        |-> rd_phys_o[PHYS_W-1:0] == '0)
        else $error("a_r6_zero_read");

endmodule

// File: tb/test_rename_table_bypass.sv
module test_rename_table_bypass;
    import rt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NRD = 4;
    localparam int NWR = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                        rst_n;
    logic [NRD*ARCH_W-1:0]       rd_arch;
    logic [NRD*PHYS_W-1:0]       rd_phys;
    logic [NWR-1:0]              wr_valid;
    logic [NWR*ARCH_W-1:0]       wr_arch;
    logic [NWR*PHYS_W-1:0]       wr_phys;
    logic                        restore;
    logic [ARCH_REGS*PHYS_W-1:0] restore_map;

    rename_table_bypass #(.NUM_RD(NRD), .NUM_WR(NWR)) i_rename_table_bypass (
        .clk(clk), .rst_n(rst_n), .rd_arch_i(rd_arch), .rd_phys_o(rd_phys),
        .wr_valid_i(wr_valid), .wr_arch_i(wr_arch), .wr_phys_i(wr_phys),
        .restore_i(restore), .restore_map_i(restore_map)
    );

    typedef struct {
        int    port;
        int    arch;
        int    exp;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    model[ARCH_REGS];
    int    ra[NRD];
    bit    wv[NWR];
    int    wa[NWR];
    int    wp[NWR];
    bit    rs;
    int    rmap[ARCH_REGS];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_writes();
        for (int j = 0; j < NWR; j++) begin
            wv[j] = 0; wa[j] = 0; wp[j] = 0;
        end
        rs = 0;
    endtask

    // Driver: apply one cycle of stimulus, update the reference map, queue expectations.
    task automatic step(input string req);
        @(negedge clk);
        for (int p = 0; p < NRD; p++) rd_arch[p*ARCH_W +: ARCH_W] = arch_idx_t'(ra[p]);
        for (int j = 0; j < NWR; j++) begin
            wr_valid[j]                   = wv[j];
            wr_arch[j*ARCH_W +: ARCH_W]   = arch_idx_t'(wa[j]);
            wr_phys[j*PHYS_W +: PHYS_W]   = phys_idx_t'(wp[j]);
        end
        restore = rs;
        for (int i = 0; i < ARCH_REGS; i++) restore_map[i*PHYS_W +: PHYS_W] = phys_idx_t'(rmap[i]);
        if (rs) begin
            for (int i = 0; i < ARCH_REGS; i++) model[i] = (i == 0) ? 0 : rmap[i];
        end else begin
            for (int j = 0; j < NWR; j++)
                if (wv[j] && wa[j] != 0) model[wa[j]] = wp[j];
        end
        for (int p = 0; p < NRD; p++) exp_q.push_back('{p, ra[p], model[ra[p]], req});
        clear_writes();
    endtask

    // Monitor: one cycle after a step, compare every read lane.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() >= NRD) begin
                for (int p = 0; p < NRD; p++) begin
                    exp_t e;
                    int   act;
                    e   = exp_q.pop_front();
                    act = int'(rd_phys[e.port*PHYS_W +: PHYS_W]);
                    check(act == e.exp, $sformatf("%s port %0d arch %0d", e.req, e.port, e.arch), act, e.exp);
                end
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst_n = 0; rd_arch = '0; wr_valid = '0; wr_arch = '0; wr_phys = '0;
        restore = 0; restore_map = '0;
        clear_writes();
        for (int i = 0; i < ARCH_REGS; i++) begin
            model[i] = i;
            rmap[i]  = 0;
        end
        for (int p = 0; p < NRD; p++) ra[p] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs are zero while reset is held
        for (int p = 0; p < NRD; p++)
            check(rd_phys[p*PHYS_W +: PHYS_W] == '0, "R9 reset output", int'(rd_phys[p*PHYS_W +: PHYS_W]), 0);
        rst_n = 1;

        // R1 and R8: identity map read out over all lanes
        for (int b = 0; b < ARCH_REGS / NRD; b++) begin
            for (int p = 0; p < NRD; p++) ra[p] = b * NRD + p;
            step("R1 identity");
        end

        // R3: write and read of the same register in one cycle
        ra = '{3, 3, 2, 4};
        wv[1] = 1; wa[1] = 3; wp[1] = 40;
        step("R3 same-cycle bypass");

        // R4: write, then read while latched, then read from the table
        ra = '{1, 1, 1, 1};
        wv[0] = 1; wa[0] = 7; wp[0] = 50;
        step("R4 write cycle");
        ra = '{7, 6, 7, 8};
        step("R4 latched read");
        ra = '{7, 7, 3, 0};
        step("R4 committed read");
        step("R2 repeat read");

        // R5: four ports hit the same register
        ra = '{9, 10, 9, 9};
        for (int j = 0; j < NWR; j++) begin
            wv[j] = 1; wa[j] = 9; wp[j] = 11 + j;
        end
        step("R5 collision bypass");
        ra = '{9, 9, 9, 9};
        step("R5 collision latched");
        step("R5 collision committed");

        // R6: writes to register 0 are ignored
        ra = '{0, 0, 9, 0};
        wv[2] = 1; wa[2] = 0; wp[2] = 33;
        step("R6 zero write");
        ra = '{0, 0, 0, 0};
        step("R6 zero latched");
        step("R6 zero committed");

        // R8: lanes are independent with partial writes
        ra = '{10, 11, 12, 13};
        wv[0] = 1; wa[0] = 11; wp[0] = 45;
        wv[3] = 1; wa[3] = 13; wp[3] = 46;
        step("R8 lane independence");
        step("R8 lane follow-up");

        // R7: restore racing a pending write and a same-cycle write
        for (int i = 0; i < ARCH_REGS; i++) rmap[i] = (i * 7 + 3) % PHYS_REGS;
        ra = '{4, 5, 6, 0};
        wv[0] = 1; wa[0] = 4; wp[0] = 60;
        step("R7 pre-restore write");
        ra = '{4, 5, 6, 0};
        rs = 1;
        wv[1] = 1; wa[1] = 5; wp[1] = 61;
        step("R7 restore cycle");
        ra = '{4, 5, 31, 1};
        step("R7 after restore");
        step("R7 settled");

        // R2: random traffic focused on few registers
        for (int n = 0; n < 400; n++) begin
            for (int p = 0; p < NRD; p++) ra[p] = $urandom_range(7);
            for (int j = 0; j < NWR; j++) begin
                wv[j] = ($urandom_range(2) != 0);
                wa[j] = $urandom_range(7);
                wp[j] = $urandom_range(PHYS_REGS - 1);
            end
            if ($urandom_range(39) == 0) begin
                rs = 1;
                for (int i = 0; i < ARCH_REGS; i++) rmap[i] = $urandom_range(PHYS_REGS - 1);
            end
            step("R2 random traffic");
        end

        ra = '{0, 0, 0, 0};
        repeat (4) @(posedge clk);
        report();
    end

endmodule